// File: doc/BRIEF.md
# ECC Error Counter and Reporter

This block sits behind a memory ECC checker and decides what each checked read beat means for error reporting. The checker flags every beat as clean, carrying a corrected single-bit error, or carrying an uncorrectable multi-bit error. Corrected single-bit errors are counted in a saturating counter. They raise a report only when the count, just after an increment, lands exactly on a programmable trigger value. Isolated corrected faults therefore stay quiet, while a run of them produces an interrupt. A multi-bit error is reported on every occurrence while reporting is enabled.

Reports are held in two sticky status bits that software clears by writing ones. The interrupt line is high while reporting is enabled and any status bit is set. The address and syndrome of the beat that caused the first report are captured. They stay frozen until every status bit has been cleared, so later errors cannot overwrite them.

Beats arrive on a valid-only flow: `beat_vld` qualifies the flags, address and syndrome in the same cycle. The block accepts a beat on every cycle, so there is no ready signal and no back-pressure toward the checker. Control and register-write pins are plain levels sampled on the clock edge.

Top module: `ecc_err_reporter`

## Requirements
- R1: Each cycle with `beat_vld` and `sbe_flag` high raises `sbe_count` by exactly one on the next clock edge. Flags seen while `beat_vld` is low have no effect on any output.
- R2: `sbe_count` saturates at 2^CNT_W-1. Further single-bit errors leave it at that value.
- R3: A cycle with `cnt_we` high loads `cnt_wdata` into the counter. This load takes precedence over an increment in the same cycle, and the load alone never raises a report.
- R4: Status bit 0 (single-bit report) is set only by an increment whose new counter value equals the trigger value, while `report_en` is high. Counts below the trigger set nothing, and a trigger of 0 never matches.
- R5: Status bit 1 (multi-bit report) is set by every beat carrying `mbe_flag` while `report_en` is high, whatever the counter and the trigger hold.
- R6: While `report_en` is low, no status bit is set, but single-bit errors are still counted.
- R7: Status bits are sticky. A cycle with `clr_we` high clears each status bit whose position in `clr_bits` is 1. A set in the same cycle wins over the clear.
- R8: `irq` is high exactly while `report_en` is high and at least one status bit is set.
- R9: `cap_addr` and `cap_syn` take the address and syndrome of the beat that sets a status bit when no status bit remains set. They hold through later errors until all status bits have been cleared.
- R10: A beat flagged with both single-bit (reaching the trigger) and multi-bit errors sets both status bits. `cap_mbit` reads 1, marking the capture as a multi-bit event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| beat_vld | input | 1 | Read beat with checker status present this cycle |
| sbe_flag | input | 1 | Beat had a corrected single-bit error |
| mbe_flag | input | 1 | Beat had an uncorrectable multi-bit error |
| beat_addr | input | ADDR_W | Address of the beat |
| beat_syn | input | SYN_W | Syndrome reported for the beat |
| report_en | input | 1 | Global error reporting enable |
| cnt_we | input | 1 | Write strobe for the single-bit counter |
| cnt_wdata | input | CNT_W | Value written to the counter |
| trig_we | input | 1 | Write strobe for the trigger value |
| trig_wdata | input | CNT_W | Trigger value written |
| clr_we | input | 1 | Write-one-to-clear strobe for status |
| clr_bits | input | 2 | Status bits to clear (bit 0 single, bit 1 multi) |
| sbe_count | output | CNT_W | Current single-bit error count |
| trig_val | output | CNT_W | Current trigger value |
| err_status | output | 2 | Sticky status (bit 0 single, bit 1 multi) |
| irq | output | 1 | Error interrupt |
| cap_addr | output | ADDR_W | Captured address of first reported error |
| cap_syn | output | SYN_W | Captured syndrome of first reported error |
| cap_mbit | output | 1 | Captured event was a multi-bit error |

## Verification
Single-bit errors are fed one at a time against trigger values of 3, 0 and the counter maximum. This shows whether a report fires on the exact match, too early, or never. Multi-bit beats are sent with the counter far from the trigger and with reporting switched off, to tell the unconditional report apart from a gated one. Bursts of differing addresses, partial clears, and a beat with both flags show whether the capture registers freeze on the first event and whether multi-bit priority applies.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
  localparam int ST_W   = 2;
  localparam int SB_BIT = 0;
  localparam int MB_BIT = 1;
endpackage

// File: rtl/ecc_sbe_counter.sv
module ecc_sbe_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             trig_we,
  input  logic [CNT_W-1:0] trig_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] trig_q,
  output logic             hit
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_nxt;
  logic             do_inc;

  assign do_inc  = inc && !cnt_we;
  assign cnt_nxt = (cnt_q == CMAX) ? CMAX : cnt_q + CNT_W'(1);
  assign hit     = do_inc && (cnt_nxt == trig_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      trig_q <= '0;
    end else begin
      if (cnt_we)      cnt_q <= cnt_wdata;
      else if (do_inc) cnt_q <= cnt_nxt;
      if (trig_we)     trig_q <= trig_wdata;
    end
  end

  // R1: an accepted increment below the maximum adds exactly one
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !cnt_we && cnt_q != CMAX) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R2: at the maximum an increment keeps the value
  a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !cnt_we && cnt_q == CMAX) |=> cnt_q == CMAX);

  // R3: a software load wins over an increment
  a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(cnt_wdata));
endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status
  import ecc_rpt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_bits,
  input  logic            clr_we,
  input  logic [ST_W-1:0] clr_bits,
  input  logic            report_en,
  output logic [ST_W-1:0] status_q,
  output logic [ST_W-1:0] status_kept,
  output logic            irq
);
  assign status_kept = clr_we ? (status_q & ~clr_bits) : status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_kept | set_bits;
  end

  assign irq = report_en && (status_q != '0);

  // R7: an uncleared status bit never drops
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[SB_BIT] && !(clr_we && clr_bits[SB_BIT])) |=> status_q[SB_BIT]);

  // R7: a set beats a simultaneous clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_bits[MB_BIT] |=> status_q[MB_BIT]);
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              held,
  input  logic              new_report,
  input  logic              new_mbit,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [SYN_W-1:0]  syn_in,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [SYN_W-1:0]  cap_syn,
  output logic              cap_mbit
);
  logic load;
  assign load = new_report && !held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_syn  <= '0;
      cap_mbit <= 1'b0;
    end else if (load) begin
      cap_addr <= addr_in;
      cap_syn  <= syn_in;
      cap_mbit <= new_mbit;
    end
  end

  // R9: while an earlier report is held, the capture is frozen
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> ($stable(cap_addr) && $stable(cap_syn) && $stable(cap_mbit)));
endmodule

// File: rtl/ecc_err_reporter.sv
module ecc_err_reporter
  import ecc_rpt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_vld,
  input  logic              sbe_flag,
  input  logic              mbe_flag,
  input  logic [ADDR_W-1:0] beat_addr,
  input  logic [SYN_W-1:0]  beat_syn,
  input  logic              report_en,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              trig_we,
  input  logic [CNT_W-1:0]  trig_wdata,
  input  logic              clr_we,
  input  logic [1:0]        clr_bits,
  output logic [CNT_W-1:0]  sbe_count,
  output logic [CNT_W-1:0]  trig_val,
  output logic [1:0]        err_status,
  output logic              irq,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [SYN_W-1:0]  cap_syn,
  output logic              cap_mbit
);
  logic            sb_hit;
  logic [ST_W-1:0] set_bits;
  logic [ST_W-1:0] kept;

  ecc_sbe_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .inc(beat_vld && sbe_flag),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata),
    .cnt_q(sbe_count), .trig_q(trig_val), .hit(sb_hit)
  );

  always_comb begin
    set_bits         = '0;
    set_bits[SB_BIT] = report_en && sb_hit;
    set_bits[MB_BIT] = report_en && beat_vld && mbe_flag;
  end

  ecc_err_status u_st (
    .clk(clk), .rst_n(rst_n),
    .set_bits(set_bits), .clr_we(clr_we), .clr_bits(clr_bits),
    .report_en(report_en),
    .status_q(err_status), .status_kept(kept), .irq(irq)
  );

  ecc_err_capture #(.ADDR_W(ADDR_W), .SYN_W(SYN_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .held(kept != '0),
    .new_report(set_bits != '0),
    .new_mbit(set_bits[MB_BIT]),
    .addr_in(beat_addr), .syn_in(beat_syn),
    .cap_addr(cap_addr), .cap_syn(cap_syn), .cap_mbit(cap_mbit)
  );

  // R6: with reporting off, no status bit can become newly set
  a_r6_no_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!report_en && err_status == '0) |=> err_status == '0);

  // R5: an enabled multi-bit beat always reports
  a_r5_mbit_report: assert property (@(posedge clk) disable iff (!rst_n)
    (report_en && beat_vld && mbe_flag) |=> err_status[MB_BIT]);
endmodule

// File: tb/sim_ecc_err_reporter.sv
module sim_ecc_err_reporter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        beat_vld = 0, sbe_flag = 0, mbe_flag = 0;
  logic [31:0] beat_addr = '0;
  logic [7:0]  beat_syn = '0;
  logic        report_en = 0;
  logic        cnt_we = 0, trig_we = 0, clr_we = 0;
  logic [7:0]  cnt_wdata = '0, trig_wdata = '0;
  logic [1:0]  clr_bits = '0;
  logic [7:0]  sbe_count, trig_val;
  logic [1:0]  err_status;
  logic        irq, cap_mbit;
  logic [31:0] cap_addr;
  logic [7:0]  cap_syn;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ecc_err_reporter u0 (
    .clk(clk), .rst_n(rst_n), .beat_vld(beat_vld), .sbe_flag(sbe_flag),
    .mbe_flag(mbe_flag), .beat_addr(beat_addr), .beat_syn(beat_syn),
    .report_en(report_en), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .clr_we(clr_we),
    .clr_bits(clr_bits), .sbe_count(sbe_count), .trig_val(trig_val),
    .err_status(err_status), .irq(irq), .cap_addr(cap_addr),
    .cap_syn(cap_syn), .cap_mbit(cap_mbit)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, results sampled at the following falling edge
  task automatic beat(bit v, bit s, bit m, logic [31:0] a, logic [7:0] y);
    beat_vld = v; sbe_flag = s; mbe_flag = m; beat_addr = a; beat_syn = y;
    @(negedge clk);
    beat_vld = 0; sbe_flag = 0; mbe_flag = 0;
  endtask

  task automatic wr_cnt(logic [7:0] d);
    cnt_we = 1; cnt_wdata = d; @(negedge clk); cnt_we = 0;
  endtask

  task automatic wr_trig(logic [7:0] d);
    trig_we = 1; trig_wdata = d; @(negedge clk); trig_we = 0;
  endtask

  task automatic clear(logic [1:0] b);
    clr_we = 1; clr_bits = b; @(negedge clk); clr_we = 0; clr_bits = '0;
  endtask

  task automatic t_reset;
    chk("R1 reset count", sbe_count, 0);
    chk("R7 reset status", err_status, 0);
    chk("R8 reset irq", irq, 0);
  endtask

  task automatic t_count;
    beat(1, 1, 0, 32'h10, 8'h01);
    chk("R1 one increment", sbe_count, 1);
    beat(0, 1, 1, 32'h14, 8'h02);
    chk("R1 flags without valid", sbe_count, 1);
    chk("R1 no status without valid", err_status, 0);
    beat(1, 1, 0, 32'h18, 8'h03);
    chk("R1 second increment", sbe_count, 2);
    chk("R4 trigger 0 never matches", err_status, 0);
  endtask

  task automatic t_trigger;
    wr_cnt(0); wr_trig(3);
    chk("R4 trigger readback", trig_val, 3);
    beat(1, 1, 0, 32'hA0, 8'h11);
    beat(1, 1, 0, 32'hA4, 8'h12);
    chk("R4 below trigger quiet", err_status, 0);
    chk("R8 no irq below trigger", irq, 0);
    beat(1, 1, 0, 32'hA8, 8'h13);
    chk("R4 report at trigger", err_status, 2'b01);
    chk("R8 irq on report", irq, 1);
    chk("R9 capture addr", cap_addr, 32'hA8);
    chk("R9 capture syn", cap_syn, 8'h13);
    chk("R10 single capture kind", cap_mbit, 0);
    beat(1, 1, 0, 32'hAC, 8'h14);
    chk("R4 past trigger no new capture", cap_addr, 32'hA8);
    clear(2'b01);
    chk("R7 w1c clears", err_status, 0);
    chk("R8 irq drops", irq, 0);
  endtask

  task automatic t_load_priority;
    wr_trig(9);
    cnt_we = 1; cnt_wdata = 8'd9;
    beat(1, 1, 0, 32'hB0, 8'h20);
    cnt_we = 0;
    chk("R3 load beats increment", sbe_count, 9);
    chk("R3 load raises no report", err_status, 0);
  endtask

  task automatic t_mbit;
    wr_trig(200); wr_cnt(0);
    beat(1, 0, 1, 32'hC0, 8'h30);
    chk("R5 multi-bit reports", err_status, 2'b10);
    chk("R9 capture mbit addr", cap_addr, 32'hC0);
    chk("R10 capture kind multi", cap_mbit, 1);
    beat(1, 0, 1, 32'hC4, 8'h31);
    chk("R9 held through later error", cap_addr, 32'hC0);
    chk("R9 held syndrome", cap_syn, 8'h30);
    clr_we = 1; clr_bits = 2'b10;
    beat(1, 0, 1, 32'hC8, 8'h32);
    clr_we = 0; clr_bits = '0;
    chk("R7 set wins over clear", err_status, 2'b10);
    report_en = 0;
    @(negedge clk);
    chk("R8 irq gated by enable", irq, 0);
    clear(2'b11);
    beat(1, 0, 1, 32'hCC, 8'h33);
    chk("R6 off: no multi report", err_status, 0);
    beat(1, 1, 0, 32'hD0, 8'h34);
    chk("R6 off: still counts", sbe_count, 1);
    report_en = 1;
  endtask

  task automatic t_both;
    wr_cnt(4); wr_trig(5);
    beat(1, 1, 1, 32'hE0, 8'h40);
    chk("R10 both bits set", err_status, 2'b11);
    chk("R10 multi priority", cap_mbit, 1);
    chk("R10 capture addr", cap_addr, 32'hE0);
    clear(2'b01);
    beat(1, 0, 1, 32'hE4, 8'h41);
    chk("R9 partial clear keeps capture", cap_addr, 32'hE0);
    clear(2'b10);
    beat(1, 0, 1, 32'hE8, 8'h42);
    chk("R9 recapture after full clear", cap_addr, 32'hE8);
    clear(2'b11);
  endtask

  task automatic t_sat;
    wr_trig(0); wr_cnt(8'd254);
    beat(1, 1, 0, 32'hF0, 8'h50);
    chk("R2 reach max", sbe_count, 255);
    beat(1, 1, 0, 32'hF4, 8'h51);
    beat(1, 1, 0, 32'hF8, 8'h52);
    chk("R2 saturated", sbe_count, 255);
    wr_trig(255); clear(2'b11);
    beat(1, 1, 0, 32'hFC, 8'h53);
    chk("R2 saturated value matches trigger", err_status, 2'b01);
    wr_cnt(0);
    chk("R3 software clear", sbe_count, 0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog actual=hung expected=done");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    report_en = 1;
    t_count();
    t_trigger();
    t_load_priority();
    t_mbit();
    t_both();
    t_sat();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule